// File: doc/BRIEF.md
# Data Memory with Pointer-Indirect Access

This block is the byte-wide data memory of a small 8-bit controller core, addressed by 8 bits. Each access is first resolved and then decoded into one region. Address 00H is a virtual location that stands for the byte addressed by pointer register P0, which sits at 01H. Address 02H does the same through pointer P1, which sits at 03H. Addresses 04H to 1FH are special-function registers held outside this block and reached through an external register port. Addresses 20H to 5FH are reserved. Addresses 60H to FFH are general-purpose RAM.

The core presents an address, write data, a byte write strobe and a bit-operation request with bit index and polarity. Read data comes back combinationally from the resolved location. A byte write or a bit set/clear takes effect at the next rising clock edge. A bit operation is a read-modify-write of the resolved byte done in a single cycle. If a pointer aims back at 00H or 02H, that access is null: it reads 00H and writes nothing.

The reset is asynchronous and active-low, and its release is expected to be synchronous to `clk`. Reset clears both pointers. RAM contents are undefined after reset.

Top module: `dmem_indirect`

## Requirements
- R1: Bytes at 60H–FFH are RAM. A byte write there is visible on `rdata` from the next clock edge, and reads are combinational.
- R2: Pointers P0 (01H) and P1 (03H) are 8-bit read/write registers, and an active reset clears both to 00H.
- R3: An access to 00H goes to the address held in P0, and an access to 02H goes to the address held in P1.
- R4: When the pointer used by 00H or 02H holds 00H or 02H, the read returns 00H and a write or bit operation changes nothing.
- R5: Addresses 20H–5FH read as 00H, and writes to them are ignored.
- R6: For a resolved address in 04H–1FH, `sfr_addr` carries that address and `rdata` equals `sfr_rdata`. A write drives `sfr_wr` high with the new byte on `sfr_wdata`.
- R7: While `sfr_ro` is high, `sfr_wr` stays low, so a read-only special-function register keeps its value.
- R8: With `bit_en` high, bit `bit_idx` (0 = LSB) of the resolved byte becomes `bit_val` (1 = set, 0 = clear) at the next edge and the other bits keep their values. This applies to RAM, pointers and special-function registers. `bit_en` takes priority over `wr_en`.
- R9: Bit operations go through indirect resolution and obey the null rule of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Access address before resolution |
| wdata | input | 8 | Byte write data |
| wr_en | input | 1 | Byte write strobe |
| bit_en | input | 1 | Bit set/clear request |
| bit_val | input | 1 | Value written by a bit operation |
| bit_idx | input | 3 | Bit position for a bit operation |
| rdata | output | 8 | Read data of the resolved location |
| sfr_addr | output | 8 | Resolved address to the external register port |
| sfr_wdata | output | 8 | Byte written to the external register |
| sfr_wr | output | 1 | External register write strobe |
| sfr_rdata | input | 8 | Read data from the external register |
| sfr_ro | input | 1 | External register at `sfr_addr` is read-only |

## Verification
A corrupted pointer is seen at the ports in the same cycle it is used. Any read of 01H or 03H shows it on `rdata` at once. An access through 00H or 02H then lands on the wrong byte, or wrongly becomes null and reads 00H. A wrong RAM byte or a bad read-modify-write mask shows up on the first read of that address, one edge after the faulty write. A wrong region decision shows either as a reserved address returning non-zero, or as `sfr_wr` pulsing for an address outside 04H–1FH or while `sfr_ro` is high.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [2:0] {
    RG_NULL = 3'd0,
    RG_PTR  = 3'd1,
    RG_SFR  = 3'd2,
    RG_RSV  = 3'd3,
    RG_RAM  = 3'd4
  } region_e;
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NPTR     = 2,
  parameter int SFR_HI   = 'h1F,
  parameter int RAM_BASE = 'h60,
  localparam int PSW     = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NPTR-1:0][ADDR_W-1:0]  ptr_q,
  output logic [ADDR_W-1:0]            res_addr,
  output region_e                      region,
  output logic [PSW-1:0]               ptr_sel
);
  localparam logic [ADDR_W-1:0] VIRT_END = ADDR_W'(2 * NPTR);
  localparam logic [ADDR_W-1:0] SFR_END  = ADDR_W'(SFR_HI);
  localparam logic [ADDR_W-1:0] RAM_LO   = ADDR_W'(RAM_BASE);

  logic indirect;

  // resolve: even slots below VIRT_END redirect through their pointer
  always_comb begin
    res_addr = addr;
    indirect = 1'b0;
    for (int k = 0; k < NPTR; k++) begin
      if (addr == ADDR_W'(2 * k)) begin
        res_addr = ptr_q[k];
        indirect = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_sel = res_addr[PSW:1];
    if (indirect && (res_addr < VIRT_END) && !res_addr[0]) begin
      region = RG_NULL;
    end else if (res_addr < VIRT_END) begin
      region = RG_PTR;
    end else if (res_addr <= SFR_END) begin
      region = RG_SFR;
    end else if (res_addr < RAM_LO) begin
      region = RG_RSV;
    end else begin
      region = RG_RAM;
    end
  end
endmodule

// File: rtl/dmem_ptr_regs.sv
module dmem_ptr_regs #(
  parameter int ADDR_W = 8,
  parameter int NPTR   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPTR-1:0]              we,
  input  logic [ADDR_W-1:0]            wdata,
  output logic [NPTR-1:0][ADDR_W-1:0]  ptr_q
);
  logic [NPTR-1:0][ADDR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    for (int k = 0; k < NPTR; k++) begin
      if (we[k]) ptr_d[k] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int RAM_BASE = 'h60,
  localparam int DEPTH   = (1 << ADDR_W) - RAM_BASE,
  localparam int IW      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] offs;
  logic [IW-1:0]     idx;
  logic              in_rng;

  always_comb begin
    offs   = addr - ADDR_W'(RAM_BASE);
    idx    = offs[IW-1:0];
    in_rng = (int'(offs) < DEPTH);
    rdata  = in_rng ? mem[idx] : '0;
  end

  always_ff @(posedge clk) begin
    if (we && in_rng) mem[idx] <= wdata;
  end
endmodule

// File: rtl/dmem_indirect.sv
module dmem_indirect
  import dmem_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int NPTR     = 2,
  parameter int SFR_HI   = 'h1F,
  parameter int RAM_BASE = 'h60,
  localparam int BIW     = $clog2(DATA_W),
  localparam int PSW     = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              bit_en,
  input  logic              bit_val,
  input  logic [BIW-1:0]    bit_idx,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] sfr_addr,
  output logic [DATA_W-1:0] sfr_wdata,
  output logic              sfr_wr,
  input  logic [DATA_W-1:0] sfr_rdata,
  input  logic              sfr_ro
);
  logic [NPTR-1:0][ADDR_W-1:0] ptr_q;
  logic [NPTR-1:0]             ptr_we;
  logic [ADDR_W-1:0]           res_addr;
  region_e                     region;
  logic [PSW-1:0]              ptr_sel;
  logic [DATA_W-1:0]           ram_rdata;
  logic [DATA_W-1:0]           rd_byte;
  logic [DATA_W-1:0]           bit_mask;
  logic [DATA_W-1:0]           wr_byte;
  logic                        do_wr;
  logic                        ram_we;

  dmem_decode #(
    .ADDR_W(ADDR_W), .NPTR(NPTR), .SFR_HI(SFR_HI), .RAM_BASE(RAM_BASE)
  ) u_dec (
    .addr(addr), .ptr_q(ptr_q), .res_addr(res_addr),
    .region(region), .ptr_sel(ptr_sel)
  );

  always_comb begin
    unique case (region)
      RG_PTR:  rd_byte = DATA_W'(ptr_q[ptr_sel]);
      RG_SFR:  rd_byte = sfr_rdata;
      RG_RAM:  rd_byte = ram_rdata;
      default: rd_byte = '0;
    endcase
  end

  // single-cycle read-modify-write for bit operations
  always_comb begin
    bit_mask = DATA_W'(1) << bit_idx;
    if (bit_en) wr_byte = bit_val ? (rd_byte | bit_mask) : (rd_byte & ~bit_mask);
    else        wr_byte = wdata;
    do_wr  = wr_en | bit_en;
    ram_we = do_wr && (region == RG_RAM);
    sfr_wr = do_wr && (region == RG_SFR) && !sfr_ro;
  end

  for (genvar k = 0; k < NPTR; k++) begin : g_ptr_we
    assign ptr_we[k] = do_wr && (region == RG_PTR) && (int'(ptr_sel) == k);
  end

  dmem_ptr_regs #(.ADDR_W(ADDR_W), .NPTR(NPTR)) u_ptr (
    .clk(clk), .rst_n(rst_n), .we(ptr_we),
    .wdata(ADDR_W'(wr_byte)), .ptr_q(ptr_q)
  );

  dmem_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE)) u_ram (
    .clk(clk), .we(ram_we), .addr(res_addr),
    .wdata(wr_byte), .rdata(ram_rdata)
  );

  assign rdata     = rd_byte;
  assign sfr_addr  = res_addr;
  assign sfr_wdata = wr_byte;
endmodule

// File: rtl/dmem_indirect_chk.sv
module dmem_indirect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] addr,
  input logic [7:0] wdata,
  input logic       wr_en,
  input logic       bit_en,
  input logic [7:0] rdata,
  input logic [7:0] sfr_addr,
  input logic       sfr_wr,
  input logic       sfr_ro,
  input logic [7:0] mp0,
  input logic [7:0] mp1
);
  logic null0, null1;
  assign null0 = (addr == 8'h00) && ((mp0 == 8'h00) || (mp0 == 8'h02));
  assign null1 = (addr == 8'h02) && ((mp1 == 8'h00) || (mp1 == 8'h02));

  a_r4_null_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (null0 || null1) |-> (rdata == 8'h00));

  a_r4_null_write_keeps_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
    ((null0 || null1) && (wr_en || bit_en)) |=> ($stable(mp0) && $stable(mp1)));

  a_r5_reserved_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr >= 8'h20) && (addr <= 8'h5F)) |-> (rdata == 8'h00));

  a_r2_ptr_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bit_en && (addr == 8'h01)) |=> (mp0 == $past(wdata)));

  a_r2_ptr_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'h03) |-> (rdata == mp1));

  a_r7_ro_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_ro |-> !sfr_wr);

  a_r6_strobe_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_wr |-> ((wr_en || bit_en) && (sfr_addr >= 8'h04) && (sfr_addr <= 8'h1F)));
endmodule

bind dmem_indirect dmem_indirect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
  .wr_en(wr_en), .bit_en(bit_en), .rdata(rdata),
  .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_ro(sfr_ro),
  .mp0(ptr_q[0]), .mp1(ptr_q[1])
);

// File: tb/dmem_indirect_tb.sv
module dmem_indirect_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       bit_en = 1'b0;
  logic       bit_val = 1'b0;
  logic [2:0] bit_idx = '0;
  logic [7:0] rdata;
  logic [7:0] sfr_addr;
  logic [7:0] sfr_wdata;
  logic       sfr_wr;
  logic [7:0] sfr_rdata;
  logic       sfr_ro;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] ext [32];

  always #5 clk = ~clk;

  dmem_indirect u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .bit_en(bit_en), .bit_val(bit_val), .bit_idx(bit_idx), .rdata(rdata),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_wr(sfr_wr),
    .sfr_rdata(sfr_rdata), .sfr_ro(sfr_ro)
  );

  // external register file model; location 0AH is read-only
  assign sfr_rdata = ext[sfr_addr[4:0]];
  assign sfr_ro    = (sfr_addr == 8'h0A);
  always @(posedge clk) if (sfr_wr) ext[sfr_addr[4:0]] <= sfr_wdata;

  // op: 0 read-check, 1 byte write, 2 bit set, 3 bit clear
  // fields: {op[28:27], addr[26:19], data[18:11], bit[10:8], expect[7:0]}
  localparam int NV = 39;
  localparam logic [28:0] VEC [NV] = '{
    {2'd1, 8'h60, 8'hA5, 3'd0, 8'h00},
    {2'd1, 8'hFF, 8'h3C, 3'd0, 8'h00},
    {2'd0, 8'h60, 8'h00, 3'd0, 8'hA5},  // R1
    {2'd0, 8'hFF, 8'h00, 3'd0, 8'h3C},  // R1
    {2'd1, 8'h01, 8'hFF, 3'd0, 8'h00},
    {2'd0, 8'h00, 8'h00, 3'd0, 8'h3C},  // R3 via P0
    {2'd1, 8'h03, 8'h60, 3'd0, 8'h00},
    {2'd0, 8'h02, 8'h00, 3'd0, 8'hA5},  // R3 via P1
    {2'd1, 8'h02, 8'h5A, 3'd0, 8'h00},
    {2'd0, 8'h60, 8'h00, 3'd0, 8'h5A},  // R3 indirect write
    {2'd0, 8'h03, 8'h00, 3'd0, 8'h60},  // R2
    {2'd0, 8'h01, 8'h00, 3'd0, 8'hFF},  // R2
    {2'd1, 8'h01, 8'h02, 3'd0, 8'h00},
    {2'd1, 8'h00, 8'h77, 3'd0, 8'h00},
    {2'd0, 8'h00, 8'h00, 3'd0, 8'h00},  // R4 read zero
    {2'd0, 8'h02, 8'h00, 3'd0, 8'h5A},  // R4 write had no effect
    {2'd0, 8'h03, 8'h00, 3'd0, 8'h60},  // R4
    {2'd0, 8'h01, 8'h00, 3'd0, 8'h02},  // R4
    {2'd1, 8'h03, 8'h00, 3'd0, 8'h00},
    {2'd0, 8'h02, 8'h00, 3'd0, 8'h00},  // R4 P1 aimed at 00H
    {2'd1, 8'h03, 8'h60, 3'd0, 8'h00},
    {2'd1, 8'h40, 8'h99, 3'd0, 8'h00},
    {2'd0, 8'h40, 8'h00, 3'd0, 8'h00},  // R5
    {2'd0, 8'h20, 8'h00, 3'd0, 8'h00},  // R5
    {2'd0, 8'h5F, 8'h00, 3'd0, 8'h00},  // R5
    {2'd1, 8'h05, 8'hC3, 3'd0, 8'h00},
    {2'd0, 8'h05, 8'h00, 3'd0, 8'hC3},  // R6
    {2'd1, 8'h0A, 8'h11, 3'd0, 8'h00},
    {2'd0, 8'h0A, 8'h00, 3'd0, 8'h00},  // R7
    {2'd2, 8'h60, 8'h00, 3'd0, 8'h00},
    {2'd0, 8'h60, 8'h00, 3'd0, 8'h5B},  // R8 set bit 0
    {2'd3, 8'h02, 8'h00, 3'd6, 8'h00},
    {2'd0, 8'h60, 8'h00, 3'd0, 8'h1B},  // R9 clear via P1
    {2'd2, 8'h01, 8'h00, 3'd7, 8'h00},
    {2'd0, 8'h01, 8'h00, 3'd0, 8'h82},  // R8 on pointer
    {2'd1, 8'h01, 8'h00, 3'd0, 8'h00},
    {2'd2, 8'h00, 8'h00, 3'd3, 8'h00},
    {2'd0, 8'h01, 8'h00, 3'd0, 8'h00},  // R9 null bit op
    {2'd3, 8'h05, 8'h00, 3'd0, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%02h actual=%02h expected=%02h", req, addr, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [7:0] a,
                       input logic [7:0] d, input logic [2:0] b);
    @(negedge clk);
    addr = a; wdata = d; bit_idx = b;
    wr_en   = (op == 2'd1);
    bit_en  = (op[1] == 1'b1);
    bit_val = (op == 2'd2);
    #1;
  endtask

  task automatic idle_read(input logic [7:0] a);
    @(negedge clk);
    addr = a; wr_en = 1'b0; bit_en = 1'b0;
    #1;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) ext[i] = 8'h00;
    repeat (2) @(negedge clk);
    idle_read(8'h01); check("R2 reset P0", rdata, 8'h00);
    idle_read(8'h03); check("R2 reset P1", rdata, 8'h00);
    rst_n = 1'b1;
    idle_read(8'h00); check("R4 reset null", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][28:27], VEC[i][26:19], VEC[i][18:11], VEC[i][10:8]);
      if (VEC[i][28:27] == 2'd0) check($sformatf("vector %0d", i), rdata, VEC[i][7:0]);
    end
    idle_read(8'h05); check("R8 clear on ext reg", rdata, 8'hC2);

    // R8 bit_en wins over wr_en
    drive(2'd1, 8'h61, 8'h00, 3'd0);
    drive(2'd1, 8'h61, 8'hFF, 3'd1);
    bit_en = 1'b1; bit_val = 1'b1;
    @(negedge clk);
    idle_read(8'h61); check("R8 priority", rdata, 8'h02);

    // R6 strobe and address seen at the port
    drive(2'd1, 8'h07, 8'h4E, 3'd0);
    check("R6 sfr_wr", {7'd0, sfr_wr}, 8'h01);
    check("R6 sfr_addr", sfr_addr, 8'h07);
    check("R6 sfr_wdata", sfr_wdata, 8'h4E);
    drive(2'd1, 8'h0A, 8'h33, 3'd0);
    check("R7 no strobe", {7'd0, sfr_wr}, 8'h00);

    // R2 reset in mid-run clears pointers
    drive(2'd1, 8'h01, 8'hAA, 3'd0);
    idle_read(8'h01); check("R2 P0 loaded", rdata, 8'hAA);
    rst_n = 1'b0;
    #1; check("R2 mid-run reset", rdata, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    idle_read(8'h03); check("R2 P1 after reset", rdata, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule